// File: doc/BRIEF.md
# Super I/O Configuration Unlock Port

This block is the configuration front end of a legacy I/O-mapped peripheral controller. The host reaches it through an index/data register pair at one of two base addresses: 0x2E (index) with 0x2F (data), or 0x4E (index) with 0x4F (data). After reset the block is locked. While locked, data-port reads return 0xFF and data-port writes change nothing.

To unlock it, the host writes a four-byte key to an index port. The key is 0x87, 0x01, 0x55, followed by a last byte that depends on the pair: 0x55 on 0x2E and 0xAA on 0x4E. Once the block is open, only the pair that carried the key responds. A byte written to its index port selects a register, and accesses to its data port read or write that register.

The register file holds four kinds of entry:
- a fixed 16-bit chip identifier;
- a global flash-control byte;
- a logical-device selector;
- a bank of base-address bytes for each logical device.

Writing 0x02 to register 0x02 locks the block again.

Top module: `sio_cfg_port`

## Requirements
- R1: Reset leaves the block locked (cfg_open_o = 0), with the register index at 0x00, the logical device at 0, the flash-control byte at 0x00 and every bank byte at 0x00.
- R2: While locked, writing 0x87, 0x01, 0x55, 0x55 to index port 0x2E opens the block. cfg_open_o rises in the cycle after the last byte is written.
- R3: While locked, writing 0x87, 0x01, 0x55, 0xAA to index port 0x4E opens the block. The sequence 0x87, 0x01, 0x55, 0x55 on 0x4E does not open it.
- R4: A byte that does not match the expected key byte restarts detection. If that byte is 0x87, it counts as the first key byte.
- R5: While locked, data-port reads return 0xFF. Data-port writes are ignored, and index-port writes do not change the selected register.
- R6: While open, an index-port write selects the register, and a data-port access reads or writes it. Registers that are not listed read 0x00. Reads from the other pair's data port return 0xFF.
- R7: Register 0x20 reads 0x87 and register 0x21 reads 0x16. Writes to them are ignored.
- R8: Register 0x07 holds the logical-device number. Registers 0x60 to 0x65 are banked per logical device, so values written under device 7 and under device 0 are kept separately.
- R9: Register 0x24 is a read/write flash-control byte. Bit 0 is the suspend flag, bits 1 to 3 enable the flash windows, bit 4 enables host writes to flash, and bit 5 selects the flash pin.
- R10: Writing 0x02 to register 0x02 locks the block in the next cycle. Any other value written to register 0x02 has no effect.
- R11: When the logical-device number is NUM_LDN or above, the banked registers read 0x00, and writes to them change no device's bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | I/O port address of the current access |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe, one access per cycle |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data, combinational from the current address |
| cfg_open_o | output | 1 | High while configuration mode is unlocked |

## Verification
The hardest state to reach is the key detector recovering partway through a sequence. One case is a stray 0x87 that must restart the key as its first byte rather than drop back to idle. Another is a detector left half-advanced on the unused pair while the other pair unlocks and relocks. The stimulus reaches these cases with directed sequences: a doubled 0x87, a key broken at its third byte and then restarted, and the wrong last byte on 0x4E. After each sequence the bench checks cfg_open_o. Banking is checked by writing the same offset under device 0, device 7 and an out-of-range device, then reading each one back.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam int          NPORT     = 2;
  localparam logic [NPORT-1:0][15:0] PORT_BASE = {16'h004E, 16'h002E};
  localparam logic [NPORT-1:0][7:0]  KEY_LAST  = {8'hAA, 8'h55};
  localparam logic [7:0]  KEY_B0    = 8'h87;
  localparam logic [7:0]  KEY_B1    = 8'h01;
  localparam logic [7:0]  KEY_B2    = 8'h55;
  localparam logic [7:0]  IDX_EXIT  = 8'h02;
  localparam logic [7:0]  EXIT_VAL  = 8'h02;
  localparam logic [7:0]  IDX_LDN   = 8'h07;
  localparam logic [7:0]  IDX_ID_HI = 8'h20;
  localparam logic [7:0]  IDX_ID_LO = 8'h21;
  localparam logic [7:0]  IDX_FCTL  = 8'h24;
  localparam logic [7:0]  IDX_BAR0  = 8'h60;
  localparam logic [15:0] CHIP_ID   = 16'h8716;
endpackage

// File: rtl/sio_key_detect.sv
module sio_key_detect
  import sio_cfg_pkg::*;
#(
  parameter logic [7:0] LAST = 8'h55
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       vld_i,
  input  logic [7:0] byte_i,
  output logic       hit_o
);
  logic [1:0] step_q;
  logic [7:0] exp_b;

  always_comb begin
    case (step_q)
      2'd0:    exp_b = KEY_B0;
      2'd1:    exp_b = KEY_B1;
      2'd2:    exp_b = KEY_B2;
      default: exp_b = LAST;
    endcase
  end

  assign hit_o = vld_i && (byte_i == exp_b) && (step_q == 2'd3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                step_q <= 2'd0;
    else if (clr_i)             step_q <= 2'd0;
    else if (vld_i) begin
      if (byte_i == exp_b)      step_q <= step_q + 2'd1;
      else if (byte_i == KEY_B0) step_q <= 2'd1;  // mismatch may start a new key
      else                      step_q <= 2'd0;
    end
  end

  assert_mismatch_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !clr_i && byte_i != exp_b && byte_i != KEY_B0) |=> step_q == 2'd0);
  assert_first_byte_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !clr_i && byte_i == KEY_B0 && step_q != 2'd1) |=> step_q == 2'd1);
endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
  import sio_cfg_pkg::*;
#(
  parameter int NUM_LDN   = 8,
  parameter int BAR_BYTES = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] idx_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       exit_o
);
  logic [7:0] ldn_q;
  logic [7:0] fctl_q;
  logic [7:0] bar_q [NUM_LDN][BAR_BYTES];

  assign exit_o = wr_i && (idx_i == IDX_EXIT) && (wdata_i == EXIT_VAL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ldn_q  <= 8'h00;
      fctl_q <= 8'h00;
    end else if (wr_i) begin
      if (idx_i == IDX_LDN)  ldn_q  <= wdata_i;
      if (idx_i == IDX_FCTL) fctl_q <= wdata_i;
    end
  end

  for (genvar l = 0; l < NUM_LDN; l++) begin : g_ldn
    for (genvar b = 0; b < BAR_BYTES; b++) begin : g_byte
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
          bar_q[l][b] <= 8'h00;
        else if (wr_i && ldn_q == 8'(l) && idx_i == IDX_BAR0 + 8'(b))
          bar_q[l][b] <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    case (idx_i)
      IDX_LDN:   rdata_o = ldn_q;
      IDX_ID_HI: rdata_o = CHIP_ID[15:8];
      IDX_ID_LO: rdata_o = CHIP_ID[7:0];
      IDX_FCTL:  rdata_o = fctl_q;
      default: begin
        for (int l = 0; l < NUM_LDN; l++)
          for (int b = 0; b < BAR_BYTES; b++)
            if (ldn_q == 8'(l) && idx_i == IDX_BAR0 + 8'(b)) rdata_o = bar_q[l][b];
      end
    endcase
  end

  assert_id_hi_fixed_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_i == IDX_ID_HI) |-> rdata_o == 8'h87);
  assert_ldn_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx_i == IDX_LDN) |=> ldn_q == $past(wdata_i));
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int NUM_LDN   = 8,
  parameter int BAR_BYTES = 6
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] addr_i,
  input  logic [7:0]  wdata_i,
  input  logic        wr_i,
  input  logic        rd_i,
  output logic [7:0]  rdata_o,
  output logic        cfg_open_o
);
  localparam int SELW = (NPORT > 1) ? $clog2(NPORT) : 1;

  logic [NPORT-1:0] idx_hit, dat_hit, key_hit;
  logic             open_q;
  logic [SELW-1:0]  sel_q, sel_n;
  logic [7:0]       index_q, rf_rdata;
  logic             sel_idx, sel_dat, rf_wr, exit_pulse;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign idx_hit[p] = (addr_i == PORT_BASE[p]);
    assign dat_hit[p] = (addr_i == PORT_BASE[p] + 16'd1);
    sio_key_detect #(.LAST(KEY_LAST[p])) u_key (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (exit_pulse || (|key_hit)),
      .vld_i  (!open_q && wr_i && idx_hit[p]),
      .byte_i (wdata_i),
      .hit_o  (key_hit[p])
    );
  end

  always_comb begin
    sel_n = sel_q;
    for (int p = 0; p < NPORT; p++)
      if (key_hit[p]) sel_n = SELW'(p);
  end

  assign sel_idx = idx_hit[sel_q];
  assign sel_dat = dat_hit[sel_q];
  assign rf_wr   = open_q && wr_i && sel_dat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q  <= 1'b0;
      sel_q   <= '0;
      index_q <= 8'h00;
    end else begin
      if (exit_pulse)             open_q <= 1'b0;
      else if (!open_q && |key_hit) begin
        open_q <= 1'b1;
        sel_q  <= sel_n;
      end
      if (open_q && wr_i && sel_idx) index_q <= wdata_i;
    end
  end

  sio_cfg_regs #(.NUM_LDN(NUM_LDN), .BAR_BYTES(BAR_BYTES)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (rf_wr),
    .idx_i   (index_q),
    .wdata_i (wdata_i),
    .rdata_o (rf_rdata),
    .exit_o  (exit_pulse)
  );

  assign rdata_o    = (open_q && rd_i && sel_dat) ? rf_rdata : 8'hFF;
  assign cfg_open_o = open_q;

  assert_unlock_needs_key_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_q) |-> $past(|key_hit));
  assert_locked_reads_ff_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_open_o && rd_i) |-> rdata_o == 8'hFF);
  assert_other_pair_ff_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !sel_dat) |-> rdata_o == 8'hFF);
  assert_exit_relocks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_q && wr_i && sel_dat && index_q == IDX_EXIT && wdata_i == EXIT_VAL) |=> !open_q);
  assert_single_key_hit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(key_hit));
endmodule

// File: tb/sio_cfg_port_tb.sv
module sio_cfg_port_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic [7:0]  wdata = 8'h00;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  rdata;
  logic        open;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  sio_cfg_port u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wdata_i(wdata),
    .wr_i(wr), .rd_i(rd), .rdata_o(rdata), .cfg_open_o(open)
  );

  // {op[29:28], addr[27:12], data/expect[11:4], req[3:0]}; op 0 write, 1 read-check, 2 open-check
  localparam int NV = 53;
  localparam logic [29:0] VEC [NV] = '{
    {2'd1,16'h002F,8'hFF,4'd5},  // R5 locked read
    {2'd2,16'h0000,8'h00,4'd1},  // R1 locked after reset
    {2'd0,16'h002F,8'h5A,4'd5},
    {2'd0,16'h002E,8'h87,4'd2}, {2'd0,16'h002E,8'h01,4'd2},
    {2'd0,16'h002E,8'h55,4'd2}, {2'd0,16'h002E,8'h55,4'd2},
    {2'd2,16'h0000,8'h01,4'd2},  // R2 open
    {2'd1,16'h002F,8'h00,4'd1},  // R1 index 0
    {2'd0,16'h002E,8'h20,4'd7}, {2'd1,16'h002F,8'h87,4'd7},
    {2'd0,16'h002F,8'h00,4'd7}, {2'd1,16'h002F,8'h87,4'd7},  // R7 read-only
    {2'd0,16'h002E,8'h21,4'd7}, {2'd1,16'h002F,8'h16,4'd7},
    {2'd0,16'h002E,8'h07,4'd1}, {2'd1,16'h002F,8'h00,4'd1},  // R1 ldn 0
    {2'd1,16'h004F,8'hFF,4'd6},  // R6 other pair
    {2'd0,16'h002E,8'h64,4'd8}, {2'd0,16'h002F,8'h11,4'd8},
    {2'd0,16'h002E,8'h07,4'd8}, {2'd0,16'h002F,8'h07,4'd8},
    {2'd0,16'h002E,8'h64,4'd8}, {2'd0,16'h002F,8'hA5,4'd8},
    {2'd0,16'h002E,8'h65,4'd8}, {2'd0,16'h002F,8'hC3,4'd8},
    {2'd1,16'h002F,8'hC3,4'd8},  // R8
    {2'd0,16'h002E,8'h64,4'd8}, {2'd1,16'h002F,8'hA5,4'd8},
    {2'd0,16'h002E,8'h07,4'd8}, {2'd0,16'h002F,8'h00,4'd8},
    {2'd0,16'h002E,8'h64,4'd8}, {2'd1,16'h002F,8'h11,4'd8},  // R8 bank 0 kept
    {2'd0,16'h002E,8'h07,4'd11}, {2'd0,16'h002F,8'h09,4'd11},
    {2'd0,16'h002E,8'h64,4'd11}, {2'd0,16'h002F,8'h77,4'd11},
    {2'd1,16'h002F,8'h00,4'd11},  // R11 out-of-range device
    {2'd0,16'h002E,8'h07,4'd11}, {2'd0,16'h002F,8'h00,4'd11},
    {2'd0,16'h002E,8'h64,4'd11}, {2'd1,16'h002F,8'h11,4'd11},
    {2'd0,16'h002E,8'h24,4'd9}, {2'd0,16'h002F,8'h3E,4'd9},
    {2'd1,16'h002F,8'h3E,4'd9},  // R9
    {2'd0,16'h002E,8'h99,4'd6}, {2'd1,16'h002F,8'h00,4'd6},  // R6 unlisted
    {2'd0,16'h002E,8'h02,4'd10}, {2'd0,16'h002F,8'h01,4'd10},
    {2'd2,16'h0000,8'h01,4'd10},  // R10 wrong value keeps open
    {2'd0,16'h002F,8'h02,4'd10},
    {2'd2,16'h0000,8'h00,4'd10},  // R10 relock
    {2'd1,16'h002F,8'hFF,4'd10}
  };

  task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [15:0] a, input logic [7:0] exp, input int req);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 check(req, rdata, exp);
    rd = 1'b0;
  endtask

  task automatic open_chk(input logic exp, input int req);
    @(negedge clk); #1 check(req, {7'd0, open}, {7'd0, exp});
  endtask

  task automatic key(input logic [15:0] a, input logic [7:0] last);
    do_wr(a, 8'h87); do_wr(a, 8'h01); do_wr(a, 8'h55); do_wr(a, last);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      op = VEC[i][29:28];
      if (op == 2'd0)      do_wr(VEC[i][27:12], VEC[i][11:4]);
      else if (op == 2'd1) rd_chk(VEC[i][27:12], VEC[i][11:4], int'(VEC[i][3:0]));
      else                 open_chk(VEC[i][4], int'(VEC[i][3:0]));
    end
    // R3: last byte depends on the pair
    key(16'h004E, 8'h55); open_chk(1'b0, 3);
    key(16'h004E, 8'hAA); open_chk(1'b1, 3);
    do_wr(16'h004E, 8'h24); rd_chk(16'h004F, 8'h3E, 6);
    rd_chk(16'h002F, 8'hFF, 6);
    do_wr(16'h004E, 8'h02); do_wr(16'h004F, 8'h02); open_chk(1'b0, 10);
    // R4: doubled first byte, then broken key, then restart mid-key
    do_wr(16'h002E, 8'h87); key(16'h002E, 8'h55); open_chk(1'b1, 4);
    do_wr(16'h002E, 8'h02); do_wr(16'h002F, 8'h02); open_chk(1'b0, 4);
    do_wr(16'h002E, 8'h87); do_wr(16'h002E, 8'h01); do_wr(16'h002E, 8'h00);
    do_wr(16'h002E, 8'h55); open_chk(1'b0, 4);
    do_wr(16'h002E, 8'h87); do_wr(16'h002E, 8'h01);
    key(16'h002E, 8'h55); open_chk(1'b1, 4);
    do_wr(16'h002E, 8'h02); do_wr(16'h002F, 8'h02); open_chk(1'b0, 4);
    // R5: locked writes leave registers and index untouched
    do_wr(16'h002E, 8'h24); do_wr(16'h002F, 8'h00);
    key(16'h002E, 8'h55); rd_chk(16'h002F, 8'h00, 5);
    do_wr(16'h002E, 8'h24); rd_chk(16'h002F, 8'h3E, 5);
    // R1: reset mid-run
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    open_chk(1'b0, 1);
    key(16'h002E, 8'h55);
    rd_chk(16'h002F, 8'h00, 1);
    do_wr(16'h002E, 8'h24); rd_chk(16'h002F, 8'h00, 1);
    do_wr(16'h002E, 8'h07); rd_chk(16'h002F, 8'h00, 1);
    do_wr(16'h002E, 8'h64); rd_chk(16'h002F, 8'h00, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule